// File: doc/BRIEF.md
# Reloadable Multi-Channel Down-Counter Timer

This block holds several independent 32-bit down-counters behind a small synchronous register bus. Each counter has its own prescaler, reload value and control word. One shared byte-wide run register starts or freezes each counter. A counter decrements on every prescaled tick. On the tick after it has reached zero it underflows: it reloads from its reload register, sets a sticky event flag and, if enabled, drives its interrupt line.

Software selects one of four tick rates for each channel. It arms a periodic event by loading equal count and reload values, and it gets a single event by loading a reload value of zero. The event flag is cleared by writing zero to it. A reload of zero parks the channel at zero after one underflow, so no further events appear until software rewrites the count or reload value.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset, every count and reload register reads 0xFFFFFFFF, every control word and the run register read 0, no channel counts, and all interrupt outputs are low.
- R2: The run register is at byte offset 0, and its bit n starts channel n. Channel n occupies offsets 4+12n (reload, 32-bit), 8+12n (count, 32-bit) and 12+12n (control, 16-bit). In the control word, bit 8 is the event flag, bit 5 is the interrupt enable and bits 2:0 are the rate code. Other control bits read 0.
- R3: bus_size 0, 1 and 2 select byte, 16-bit and 32-bit accesses. Write data sits on the byte lanes given by the low address bits, and only those lanes of the addressed register change. A read returns the whole aligned register word.
- R4: While a channel's run bit is clear, its count holds. After the run bit is set, the first tick arrives one full prescaler period later: for a divider D, the count first changes on the D-th clock edge after the edge that sets the bit.
- R5: Rate codes 0, 1, 2 and 3 give one tick every 4, 16, 64 and 256 clocks.
- R6: Rate codes 4 to 7 behave as code 0 (one tick every 4 clocks).
- R7: On a tick with a non-zero count, the count decrements by one. On a tick with the count at zero, the count takes the reload register's current value.
- R8: Every underflow sets the event flag. The flag stays set when software writes 1 to bit 8 and clears when software writes 0 to it. An underflow in the same cycle as a clearing write leaves the flag set.
- R9: A channel's interrupt output is high exactly when both its enable bit and its event flag are set.
- R10: With a reload value of zero, the channel underflows once, then holds at zero and raises no further flags until its count or reload register is written.
- R11: A bus write to a count register in the same cycle as a tick stores the written value, and neither the decrement nor the reload takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| bus_wdata | input | 32 | Write data, lane aligned |
| bus_rdata | output | 32 | Read data of the addressed word (0 when not selected) |
| irq | output | NCH | Per-channel interrupt |

## Verification
A corrupted count shows as a wrong value the next time the count register is read back after the channel is frozen. A prescaler phase error shifts the number of ticks within a fixed run window, so the frozen count differs by one from the expected value. A lost or spurious flag appears in the control read and on the interrupt pin in the cycle after the underflow. Write-versus-tick priority and zero-reload parking are checked by placing a write on an exact tick edge and by running a parked channel across many tick periods.

// File: rtl/ttu_pkg.sv
`timescale 1ns/1ps
package ttu_pkg;
    localparam int CW      = 32;
    localparam int PRE_W   = 8;
    localparam int AW      = 8;
    localparam int CH_BASE = 4;
    localparam int STRIDE  = 12;

    typedef struct packed {
        logic       uf;
        logic       ie;
        logic [2:0] psc;
    } ctrl_t;

    // Byte-lane enables for a lane-aligned access
    function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            2'd0:    return 4'b0001 << a;
            2'd1:    return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [CW-1:0] lane_merge(input logic [CW-1:0] old,
                                                 input logic [CW-1:0] wd,
                                                 input logic [3:0] m);
        logic [CW-1:0] r;
        for (int b = 0; b < 4; b++)
            r[b*8 +: 8] = m[b] ? wd[b*8 +: 8] : old[b*8 +: 8];
        return r;
    endfunction

    // Last prescaler state for a rate code; reserved codes fold to divide-by-4
    function automatic logic [PRE_W-1:0] pre_last(input logic [2:0] psc);
        case (psc)
            3'd1:    return PRE_W'(15);
            3'd2:    return PRE_W'(63);
            3'd3:    return PRE_W'(255);
            default: return PRE_W'(3);
        endcase
    endfunction

    function automatic logic [15:0] ctrl_pack(input ctrl_t c);
        return {7'b0, c.uf, 2'b0, c.ie, 2'b0, c.psc};
    endfunction

    // Control word after a bus write; the flag field carries the written bit
    function automatic ctrl_t ctrl_apply(input ctrl_t old, input logic [CW-1:0] wd,
                                         input logic [3:0] m);
        ctrl_t r;
        r.uf  = m[1] ? wd[8]   : old.uf;
        r.ie  = m[0] ? wd[5]   : old.ie;
        r.psc = m[0] ? wd[2:0] : old.psc;
        return r;
    endfunction
endpackage

// File: rtl/ttu_prescaler.sv
`timescale 1ns/1ps
module ttu_prescaler
    import ttu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] psc,
    output logic       tick
);
    logic [PRE_W-1:0] pc_q;
    logic [PRE_W-1:0] last;

    assign last = pre_last(psc);
    assign tick = run && (pc_q >= last);

    // Held at zero while stopped, so a restart begins a full period
    always_ff @(posedge clk) begin
        if (rst || !run)  pc_q <= '0;
        else if (tick)    pc_q <= '0;
        else              pc_q <= pc_q + 1'b1;
    end
endmodule

// File: rtl/ttu_channel.sv
`timescale 1ns/1ps
module ttu_channel
    import ttu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wval,
    input  logic          cst_wr,
    input  logic [CW-1:0] cst_wval,
    input  logic          ctl_wr,
    input  ctrl_t         ctl_wval,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cst,
    output ctrl_t         ctl,
    output logic          tick,
    output logic          irq
);
    logic [CW-1:0] cnt_q, cst_q;
    ctrl_t         ctl_q;
    logic          parked_q;
    logic          uflow;

    ttu_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .psc  (ctl_q.psc),
        .tick (tick)
    );

    assign uflow = tick && (cnt_q == '0) && !parked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '1;
            cst_q    <= '1;
            ctl_q    <= '0;
            parked_q <= 1'b0;
        end else begin
            if (cst_wr) cst_q <= cst_wval;

            if (cnt_wr)                       cnt_q <= cnt_wval;
            else if (uflow)                   cnt_q <= cst_q;
            else if (tick && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;

            if (cnt_wr || cst_wr)             parked_q <= 1'b0;
            else if (uflow && cst_q == '0)    parked_q <= 1'b1;

            if (ctl_wr) begin
                ctl_q.ie  <= ctl_wval.ie;
                ctl_q.psc <= ctl_wval.psc;
            end
            ctl_q.uf <= ((ctl_wr ? ctl_wval.uf : 1'b1) & ctl_q.uf) | uflow;
        end
    end

    assign cnt = cnt_q;
    assign cst = cst_q;
    assign ctl = ctl_q;
    assign irq = ctl_q.ie & ctl_q.uf;
endmodule

// File: rtl/tick_timer_unit.sv
`timescale 1ns/1ps
module tick_timer_unit
    import ttu_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [1:0]     bus_size,
    input  logic [CW-1:0]  bus_wdata,
    output logic [CW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);
    localparam int WIW = AW - 2;

    logic [WIW-1:0] widx;
    logic [3:0]     mask;
    logic           wr;
    logic [NCH-1:0] start_q;

    logic [NCH-1:0][CW-1:0] cnt_v, cst_v, cnt_wv;
    ctrl_t [NCH-1:0]        ctl_v;
    logic  [NCH-1:0]        tick_v, cnt_wr_v, ctl_wr_v;

    assign widx = bus_addr[AW-1:2];
    assign mask = lane_mask(bus_size, bus_addr[1:0]);
    assign wr   = bus_sel && bus_wr;

    always_ff @(posedge clk) begin
        if (rst)                                start_q <= '0;
        else if (wr && widx == '0 && mask[0])   start_q <= bus_wdata[NCH-1:0];
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam int WC = (CH_BASE + STRIDE * n) / 4;
        logic hit_c, hit_n, hit_k;
        assign hit_c = wr && (widx == WIW'(WC));
        assign hit_n = wr && (widx == WIW'(WC + 1));
        assign hit_k = wr && (widx == WIW'(WC + 2));
        assign cnt_wr_v[n] = hit_n;
        assign ctl_wr_v[n] = hit_k;
        assign cnt_wv[n]   = lane_merge(cnt_v[n], bus_wdata, mask);

        ttu_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .run      (start_q[n]),
            .cnt_wr   (hit_n),
            .cnt_wval (cnt_wv[n]),
            .cst_wr   (hit_c),
            .cst_wval (lane_merge(cst_v[n], bus_wdata, mask)),
            .ctl_wr   (hit_k),
            .ctl_wval (ctrl_apply(ctl_v[n], bus_wdata, mask)),
            .cnt      (cnt_v[n]),
            .cst      (cst_v[n]),
            .ctl      (ctl_v[n]),
            .tick     (tick_v[n]),
            .irq      (irq[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (widx == '0) bus_rdata = {{(CW-NCH){1'b0}}, start_q};
            for (int n = 0; n < NCH; n++) begin
                if (widx == WIW'((CH_BASE + STRIDE * n) / 4))     bus_rdata = cst_v[n];
                if (widx == WIW'((CH_BASE + STRIDE * n) / 4 + 1)) bus_rdata = cnt_v[n];
                if (widx == WIW'((CH_BASE + STRIDE * n) / 4 + 2)) bus_rdata = {16'b0, ctrl_pack(ctl_v[n])};
            end
        end
    end
endmodule

// File: rtl/ttu_checker.sv
`timescale 1ns/1ps
module ttu_checker
    import ttu_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NCH-1:0]         tick,
    input logic [NCH-1:0][CW-1:0] cnt,
    input logic [NCH-1:0][CW-1:0] cst,
    input logic [NCH-1:0][CW-1:0] cnt_wval,
    input logic [NCH-1:0]         cnt_wr,
    input logic [NCH-1:0]         ctl_wr,
    input ctrl_t [NCH-1:0]        ctl
);
    for (genvar n = 0; n < NCH; n++) begin : g_a
        p_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (!tick[n] && !cnt_wr[n]) |=> $stable(cnt[n]));
        p_decrement_r7: assert property (@(posedge clk) disable iff (rst)
            (tick[n] && cnt[n] != '0 && !cnt_wr[n]) |=> cnt[n] == $past(cnt[n]) - 1'b1);
        p_reload_r7: assert property (@(posedge clk) disable iff (rst)
            (tick[n] && cnt[n] == '0 && cst[n] != '0 && !cnt_wr[n]) |=> cnt[n] == $past(cst[n]));
        p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
            (tick[n] && cnt[n] == '0 && cst[n] != '0) |=> ctl[n].uf);
        p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
            (ctl[n].uf && !ctl_wr[n]) |=> ctl[n].uf);
        p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
            cnt_wr[n] |=> cnt[n] == $past(cnt_wval[n]));
    end
endmodule

bind tick_timer_unit ttu_checker #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_v),
    .cnt      (cnt_v),
    .cst      (cst_v),
    .cnt_wval (cnt_wv),
    .cnt_wr   (cnt_wr_v),
    .ctl_wr   (ctl_wr_v),
    .ctl      (ctl_v)
);

// File: tb/sim_tick_timer_unit.sv
`timescale 1ns/1ps
module sim_tick_timer_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 = read data, 1 = interrupt vector
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    tick_timer_unit #(.NCH(3)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] a_cst(input int n); return 8'(4 + 12 * n);  endfunction
    function automatic logic [7:0] a_cnt(input int n); return 8'(8 + 12 * n);  endfunction
    function automatic logic [7:0] a_ctl(input int n); return 8'(12 + 12 * n); endfunction

    // Monitor: compares queued expectations away from the clock edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = (it.kind == 0) ? bus_rdata : {29'b0, irq};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic op_idle();
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic op_wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
    endtask

    task automatic op_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_size = 2'd2;
        it.kind = 0; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic op_irq(input logic [2:0] exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
        it.kind = 1; it.exp = {29'b0, exp}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Runs the masked channels for floor((m+1)/D) ticks, then freezes them
    task automatic run_for(input logic [2:0] chm, input int m);
        op_wr(8'd0, 2'd0, {29'b0, chm});
        repeat (m) op_idle();
        op_wr(8'd0, 2'd0, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        op_rd(8'd0, 32'h0, "R1 run register");
        op_rd(a_cnt(0), 32'hFFFF_FFFF, "R1 count0");
        op_rd(a_cst(1), 32'hFFFF_FFFF, "R1 reload1");
        op_rd(a_ctl(2), 32'h0, "R1 control2");
        op_irq(3'b000, "R1 irq");

        // R2 layout
        op_wr(a_cst(1), 2'd2, 32'h55);
        op_rd(a_cst(1), 32'h55, "R2 reload1");
        op_rd(a_cnt(1), 32'hFFFF_FFFF, "R2 count1 untouched");
        op_wr(8'd0, 2'd0, 32'h5);
        op_rd(8'd0, 32'h5, "R2 run register");
        op_wr(8'd0, 2'd0, 32'h0);

        // R3 lanes
        op_wr(a_cnt(2) + 8'd1, 2'd0, 32'h0000_AB00);
        op_rd(a_cnt(2), 32'hFFFF_ABFF, "R3 byte lane 1");
        op_wr(a_ctl(2) + 8'd2, 2'd1, 32'hFFFF_0000);
        op_rd(a_ctl(2), 32'h0, "R3 upper half of control");

        // R5 divide by 4
        op_wr(a_ctl(0), 2'd1, 32'h0);
        op_wr(a_cst(0), 2'd2, 32'd10);
        op_wr(a_cnt(0), 2'd2, 32'd10);
        run_for(3'b001, 13);
        op_rd(a_cnt(0), 32'd7, "R5 divide by 4");
        // R4 hold while stopped, full first period
        repeat (5) op_idle();
        op_rd(a_cnt(0), 32'd7, "R4 hold");
        op_wr(a_cnt(0), 2'd2, 32'd50);
        run_for(3'b001, 2);
        op_rd(a_cnt(0), 32'd50, "R4 first tick late");

        // R5 divide by 16, 64, 256
        op_wr(a_ctl(1), 2'd1, 32'h1);
        op_wr(a_cnt(1), 2'd2, 32'd5);
        run_for(3'b010, 50);
        op_rd(a_cnt(1), 32'd2, "R5 divide by 16");
        op_wr(a_ctl(2), 2'd1, 32'h2);
        op_wr(a_cnt(2), 2'd2, 32'd3);
        op_wr(a_cst(2), 2'd2, 32'd7);
        run_for(3'b100, 200);
        op_rd(a_cnt(2), 32'd0, "R5 divide by 64");
        op_rd(a_ctl(2), 32'h2, "R8 no flag before underflow");
        op_wr(a_ctl(2), 2'd1, 32'h3);
        op_wr(a_cnt(2), 2'd2, 32'd1);
        run_for(3'b100, 600);
        op_rd(a_cnt(2), 32'd7, "R5 divide by 256 reload");
        op_rd(a_ctl(2), 32'h103, "R8 flag on underflow");
        op_irq(3'b000, "R9 flag without enable");

        // R6 reserved code
        op_wr(a_ctl(1), 2'd1, 32'h5);
        op_wr(a_cnt(1), 2'd2, 32'd100);
        run_for(3'b010, 41);
        op_rd(a_cnt(1), 32'd90, "R6 reserved code");

        // R7 underflow and reload, R9 interrupt
        op_wr(a_ctl(0), 2'd1, 32'h20);
        op_wr(a_cst(0), 2'd2, 32'd3);
        op_wr(a_cnt(0), 2'd2, 32'd2);
        run_for(3'b001, 15);
        op_rd(a_cnt(0), 32'd2, "R7 reload then decrement");
        op_rd(a_ctl(0), 32'h120, "R8 flag set");
        op_irq(3'b001, "R9 irq0");

        // R8 sticky flag
        op_wr(a_ctl(0), 2'd1, 32'h120);
        op_rd(a_ctl(0), 32'h120, "R8 write 1 keeps");
        op_wr(a_ctl(0), 2'd1, 32'h20);
        op_rd(a_ctl(0), 32'h20, "R8 write 0 clears");
        op_irq(3'b000, "R9 irq after clear");
        op_wr(a_ctl(2), 2'd1, 32'h123);
        op_irq(3'b100, "R9 enable on flagged channel");
        op_wr(a_ctl(2), 2'd1, 32'h3);
        op_irq(3'b000, "R9 channel 2 cleared");

        // R10 zero reload parks the channel
        op_wr(a_cst(0), 2'd2, 32'd0);
        op_wr(a_cnt(0), 2'd2, 32'd1);
        run_for(3'b001, 39);
        op_rd(a_cnt(0), 32'd0, "R10 parked count");
        op_rd(a_ctl(0), 32'h120, "R10 single flag");
        op_wr(a_ctl(0), 2'd1, 32'h20);
        run_for(3'b001, 39);
        op_rd(a_ctl(0), 32'h20, "R10 no further flag");
        op_rd(a_cnt(0), 32'd0, "R10 still zero");
        op_irq(3'b000, "R10 irq quiet");

        // R11 write on a tick edge
        op_wr(a_ctl(1), 2'd1, 32'h0);
        op_wr(a_cnt(1), 2'd2, 32'd40);
        op_wr(8'd0, 2'd0, 32'h2);
        repeat (3) op_idle();
        op_wr(a_cnt(1), 2'd2, 32'd1000);
        op_wr(8'd0, 2'd0, 32'h0);
        op_rd(a_cnt(1), 32'd1000, "R11 write wins");

        op_idle();
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule